// File: doc/BRIEF.md
# Link Pulse Burst Encoder

This block turns a 16-bit link code word into a train of single-cycle pulse requests for an analog link-pulse driver. One burst has 33 equally spaced slots. The first slot and every second slot after it are framing (clock) slots and always carry a pulse. The 16 slots in between are data slots, one per code-word bit: a pulse means 1 and an empty slot means 0. The code word is sent unchanged, so its low five bits carry the selector field (the value for IEEE 802.3 compliance). The bits above them carry the local ability advertisement: 10/100 half and full duplex, pause modes, remote fault and next page.

A start strobe launches the first burst. The block then launches a fresh burst at a fixed period, measured from one burst's first pulse to the next one's, until a stop input is seen. Slot spacing and burst period are parameters counted in system-clock ticks. Their defaults give 62.5 µs and 16 ms at a 50 MHz clock. The code word is sampled again at every launch. A done flag marks the last pulse of each burst.

Top module: `flp_burst_enc`

## Requirements
- R1: After reset, `pulse_o` and `burst_done_o` are low and no pulse appears until a start is accepted.
- R2: When `start_i` is high and `stop_i` is low at a clock edge while the block is idle, a burst begins. Its first pulse is high in the cycle after that edge, and slot k is high SLOT_TICKS*k cycles later, for k = 0 to 32.
- R3: Every clock slot always carries a pulse. These are the slots with an even 0-based index (0, 2, ... 32).
- R4: Data slot 2b+1 carries code-word bit b, least significant bit first: a pulse for 1, no pulse for 0.
- R5: Each pulse lasts exactly one clock cycle, and `pulse_o` is low in every cycle between slots.
- R6: `burst_done_o` is high for exactly one cycle, the cycle of the final clock pulse of a burst, and is low otherwise.
- R7: The code word is captured when a burst launches. Changes on `code_word_i` during a burst have no effect on that burst.
- R8: `start_i` is ignored while a burst or the gap after it is in progress.
- R9: Without stop, the next burst's first pulse comes exactly BURST_TICKS cycles after the previous burst's first pulse. It carries the code word present at that launch edge.
- R10: A stop seen during a burst lets that burst finish all 33 slots, and no further burst follows.
- R11: A stop seen in the gap between bursts prevents any further burst.
- R12: A start that arrives together with a stop while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe, taken only while idle |
| stop_i | input | 1 | Ends the repetition of bursts |
| code_word_i | input | 16 | Link code word, bit 0 sent first |
| pulse_o | output | 1 | Single-cycle pulse request to the driver |
| burst_done_o | output | 1 | High with the last pulse of a burst |

## Verification
The bench builds the block with SLOT_TICKS = 4 and BURST_TICKS = 200. With these values a whole burst of 129 cycles, its gap and the following launch fit in a few hundred cycles. Every cycle of a burst can therefore be compared with the expected slot pattern, including the empty cycles between slots. The short period also brings the repeat launch, with its freshly sampled code word, within reach. So do stops placed both inside a burst and inside the gap, and a start given while idle together with a stop.

// File: rtl/flp_pkg.sv
package flp_pkg;
   localparam int FLP_DATA_BITS = 16;
   typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_GAP} flp_state_e;
endpackage

// File: rtl/flp_slot_map.sv
module flp_slot_map #(
   parameter int DATA_BITS = 16
) (
   input  logic [DATA_BITS-1:0] word_i,
   output logic [2*DATA_BITS:0] pattern_o
);
   localparam int NSLOTS = 2*DATA_BITS + 1;
   for (genvar k = 0; k < NSLOTS; k++) begin : g_slot
      if (k % 2 == 0) begin : g_clk
         assign pattern_o[k] = 1'b1;
      end else begin : g_dat
         assign pattern_o[k] = word_i[k/2];
      end
   end
endmodule

// File: rtl/flp_mod_cnt.sv
module flp_mod_cnt #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic en_i,
   output logic last_o
);
   localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [W-1:0] TOP = W'(LIMIT - 1);
   logic [W-1:0] cnt_q;

   assign last_o = en_i && (cnt_q == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (en_i)    cnt_q <= last_o ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/flp_ctrl.sv
module flp_ctrl
   import flp_pkg::*;
#(
   parameter int DATA_BITS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic [DATA_BITS-1:0] word_i,
   input  logic [2*DATA_BITS:0] pattern_i,
   input  logic                 slot_last_i,
   input  logic                 period_last_i,
   output logic [DATA_BITS-1:0] word_q_o,
   output logic                 launch_o,
   output logic                 in_burst_o,
   output logic                 active_o,
   output logic                 pulse_o,
   output logic                 done_o
);
   localparam int NSLOTS = 2*DATA_BITS + 1;
   localparam int SW     = $clog2(NSLOTS);
   localparam logic [SW-1:0] PENULT = SW'(NSLOTS - 2);

   flp_state_e   state_q;
   logic [SW-1:0] slot_q;
   logic [SW-1:0] slot_nxt;
   logic          stop_pend_q;

   assign slot_nxt   = slot_q + 1'b1;
   assign launch_o   = !stop_i && ((state_q == ST_IDLE && start_i) ||
                                   (state_q == ST_GAP  && period_last_i));
   assign in_burst_o = (state_q == ST_BURST);
   assign active_o   = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         slot_q      <= '0;
         stop_pend_q <= 1'b0;
         word_q_o    <= '0;
         pulse_o     <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         pulse_o <= 1'b0;
         done_o  <= 1'b0;
         if (launch_o) begin
            state_q     <= ST_BURST;
            word_q_o    <= word_i;
            slot_q      <= '0;
            stop_pend_q <= 1'b0;
            pulse_o     <= 1'b1;
         end else begin
            unique case (state_q)
               ST_IDLE: stop_pend_q <= 1'b0;
               ST_BURST: begin
                  if (stop_i) stop_pend_q <= 1'b1;
                  if (slot_last_i) begin
                     slot_q  <= slot_nxt;
                     pulse_o <= pattern_i[slot_nxt];
                     if (slot_q == PENULT) begin
                        done_o  <= 1'b1;
                        state_q <= (stop_pend_q || stop_i) ? ST_IDLE : ST_GAP;
                     end
                  end
               end
               ST_GAP: if (stop_i) state_q <= ST_IDLE;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/flp_burst_enc.sv
module flp_burst_enc #(
   parameter int DATA_BITS   = flp_pkg::FLP_DATA_BITS,
   parameter int SLOT_TICKS  = 3125,
   parameter int BURST_TICKS = 800000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic [DATA_BITS-1:0] code_word_i,
   output logic                 pulse_o,
   output logic                 burst_done_o
);
   localparam int NSLOTS = 2*DATA_BITS + 1;

   if (SLOT_TICKS < 2) begin : g_chk_slot
      $error("SLOT_TICKS must be at least 2");
   end
   if (BURST_TICKS <= (NSLOTS - 1) * SLOT_TICKS) begin : g_chk_period
      $error("BURST_TICKS must exceed the span of one burst");
   end
   if (DATA_BITS < 1) begin : g_chk_bits
      $error("DATA_BITS must be positive");
   end

   logic [DATA_BITS-1:0] word_q;
   logic [NSLOTS-1:0]    pattern;
   logic launch, in_burst, active, slot_last, period_last;

   flp_slot_map #(.DATA_BITS(DATA_BITS)) map_i (
      .word_i(word_q), .pattern_o(pattern));

   flp_mod_cnt #(.LIMIT(SLOT_TICKS)) slot_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr_i(launch), .en_i(in_burst),
      .last_o(slot_last));

   flp_mod_cnt #(.LIMIT(BURST_TICKS)) period_cnt_i (
      .clk(clk), .rst_n(rst_n), .clr_i(launch), .en_i(active),
      .last_o(period_last));

   flp_ctrl #(.DATA_BITS(DATA_BITS)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .word_i(code_word_i), .pattern_i(pattern),
      .slot_last_i(slot_last), .period_last_i(period_last),
      .word_q_o(word_q), .launch_o(launch), .in_burst_o(in_burst),
      .active_o(active), .pulse_o(pulse_o), .done_o(burst_done_o));
endmodule

// File: rtl/flp_burst_enc_chk.sv
module flp_burst_enc_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic stop_i,
   input logic pulse_o,
   input logic burst_done_o,
   input logic active
);
   // R5
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
   // R6
   done_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done_o |-> pulse_o);
   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done_o |=> !burst_done_o);
   // R11
   stop_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !active) |=> !pulse_o);
   // R12
   stop_beats_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && start_i && stop_i) |=> !pulse_o);
   // R2
   launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && start_i && !stop_i) |=> pulse_o);
endmodule

bind flp_burst_enc flp_burst_enc_chk chk_i (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
   .pulse_o(pulse_o), .burst_done_o(burst_done_o), .active(active));

// File: tb/flp_burst_enc_tb_top.sv
module flp_burst_enc_tb_top;
   localparam int S  = 4;
   localparam int BP = 200;
   localparam int LASTC = 32 * S;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic stop_i = 1'b0;
   logic [15:0] code_word_i = '0;
   logic pulse_o, burst_done_o;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   flp_burst_enc #(.DATA_BITS(16), .SLOT_TICKS(S), .BURST_TICKS(BP)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .code_word_i(code_word_i), .pulse_o(pulse_o), .burst_done_o(burst_done_o));

   function automatic logic [32:0] pat(input logic [15:0] w);
      logic [32:0] p;
      for (int k = 0; k < 33; k++) p[k] = (k % 2 == 0) ? 1'b1 : w[k/2];
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Called at the negedge where slot 0 should be visible; returns at c = LASTC.
   task automatic observe(input logic [15:0] w, input bit disturb);
      logic [32:0] p = pat(w);
      for (int c = 0; c <= LASTC; c++) begin
         logic ep;
         string req;
         ep = (c % S == 0) ? p[c/S] : 1'b0;
         if (c == 0)               req = "R2 first slot";
         else if (c % S != 0)      req = "R5 empty cycle";
         else if ((c/S) % 2 == 0)  req = "R3 clock slot";
         else                      req = "R4 data slot";
         if (disturb) req = {req, " under R7 R8 R10 disturbance"};
         check(pulse_o == ep, req, pulse_o, ep);
         check(burst_done_o == (c == LASTC), "R6 done flag", burst_done_o, c == LASTC);
         if (disturb) begin
            if (c == 10) begin code_word_i = ~w; start_i = 1'b1; end
            if (c == 11) start_i = 1'b0;
            if (c == 20) stop_i = 1'b1;
            if (c == 21) stop_i = 1'b0;
         end
         if (c < LASTC) @(negedge clk);
      end
   endtask

   task automatic quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(pulse_o == 1'b0, req, pulse_o, 0);
      end
   endtask

   task automatic launch(input logic [15:0] w);
      @(negedge clk);
      code_word_i = w; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(pulse_o == 1'b0, "R1 pulse in reset", pulse_o, 0);
      check(burst_done_o == 1'b0, "R1 done in reset", burst_done_o, 0);
      rst_n = 1'b1;
      quiet(10, "R1 quiet after reset");
   endtask

   task automatic t_repeat;
      launch(16'h05E1);
      observe(16'h05E1, 1'b0);
      for (int c = LASTC + 1; c < BP; c++) begin
         @(negedge clk);
         check(pulse_o == 1'b0, "R9 R8 gap quiet", pulse_o, 0);
         if (c == 150) start_i = 1'b1;
         if (c == 151) start_i = 1'b0;
         if (c == 170) code_word_i = 16'h1234;
      end
      @(negedge clk);
      observe(16'h1234, 1'b1);
      quiet(300, "R10 no burst after stop in burst");
   endtask

   task automatic t_stop_gap;
      launch(16'h8001);
      observe(16'h8001, 1'b0);
      for (int c = LASTC + 1; c < 400; c++) begin
         @(negedge clk);
         check(pulse_o == 1'b0, "R11 stop in gap", pulse_o, 0);
         if (c == 140) stop_i = 1'b1;
         if (c == 141) stop_i = 1'b0;
      end
   endtask

   task automatic t_start_stop;
      @(negedge clk);
      code_word_i = 16'hFFFF; start_i = 1'b1; stop_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      check(pulse_o == 1'b0, "R12 start with stop", pulse_o, 0);
      quiet(40, "R12 stays idle");
      launch(16'h0000);
      observe(16'h0000, 1'b0);
      @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      quiet(250, "R11 stop right after burst");
      launch(16'hFFFF);
      observe(16'hFFFF, 1'b0);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
   endtask

   initial begin
      t_reset;
      t_repeat;
      t_stop_gap;
      t_start_stop;
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule